// File: doc/BRIEF.md
# Contrast-Voltage Pulse Burst Generator

This block drives a single output pin with a finite train of pulses for a contrast-voltage charge circuit. Software chooses a divide select `x` and a burst length `y`, then issues a start strobe. The block emits `y` pulses. Each pulse stays high for `2^x` source-clock cycles and low for `2^x` cycles, so the pulse rate is the source clock divided by `2^x * 2`.

A status output stays high while a burst is running, so software can poll for completion. The start strobe is a one-shot request: a strobe that cannot begin a burst is discarded, which keeps the start bit self-clearing in effect.

An enable input gates the whole pulse circuit. A force-high input overrides the pin to a constant high level, which lets the pin serve as a plain output. Bus decoding and the analog circuit on the pin are outside this block.

Top module: `cv_burst_gen`

## Requirements
- R1: During a burst with divide select x, the pin is high for exactly 2^x cycles and then low for exactly 2^x cycles, repeating for each pulse.
- R2: A burst with burst_len = y (1 to 2^LEN_W-1) produces exactly y rising edges on `cv_out`. The first pulse goes high on the clock edge that samples the accepted `start`.
- R3: `burst_busy` rises on the same edge as the first pulse and falls on the same edge as the falling edge of the last pulse. It is therefore high for (2y-1)*2^x cycles.
- R4: While `force_high` = 1, `cv_out` is 1 in the same cycle, whatever `enable` is. A burst already running keeps its timing and status underneath the override.
- R5: A `start` that arrives while a burst is running is ignored. The divide select and burst length are captured when a burst is accepted, and changes to them during the burst have no effect.
- R6: While `enable` = 0, `cv_out` is 0 (unless forced) in the same cycle. A running burst is aborted, so `burst_busy` is 0 after the next edge. A `start` seen while disabled is discarded, and re-enabling does not resume or begin a burst.
- R7: A `start` with `burst_len` = 0 is ignored, and `burst_busy` stays 0.
- R8: A synchronous reset (`rst_n` = 0 at a rising edge) clears `cv_out` and `burst_busy`, also in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Pulse circuit enable; 0 aborts a burst |
| force_high | input | 1 | Drives `cv_out` high, overriding the pulse logic |
| start | input | 1 | One-cycle burst start request |
| div_sel | input | DIV_W | Divide select x; half period is 2^x cycles |
| burst_len | input | LEN_W | Number of pulses y per burst |
| cv_out | output | 1 | Pulse output pin |
| burst_busy | output | 1 | Status: 1 while a burst is running |

## Verification
Pulse state and status are registered. Both change on the first rising edge that samples an accepted `start`, and after that on every edge that ends a half period. The `force_high` and `enable` overrides reach `cv_out` combinationally, in the same cycle, while the abort reaches `burst_busy` one edge later. The bench drives every input on the falling edge and compares on the following falling edges. Its expected waveform comes from the cycle index t counted from the accepting edge: busy while t < (2y-1)*2^x, and high while (t / 2^x) is even. Combinational overrides are sampled one time step after the driving falling edge.

// File: rtl/cvb_pkg.sv
// Package: shared defaults and the output source encoding for the
// contrast-voltage burst generator. Assumes nothing about the clock.
package cvb_pkg;
    localparam int CVB_DIV_W = 3;   // default divide-select width
    localparam int CVB_LEN_W = 8;   // default burst-length width

    // Which level the output pin currently follows.
    typedef enum logic [1:0] {
        SRC_LOW   = 2'd0,
        SRC_PULSE = 2'd1,
        SRC_HIGH  = 2'd2
    } cvb_src_e;
endpackage

// File: rtl/cvb_prescaler.sv
// Module: cvb_prescaler
// Produces a one-cycle tick every 2^div_sel cycles while run is high.
// Assumes div_sel is held stable for as long as run is high (the caller
// latches it at burst start). restart or a low run clears the count.
module cvb_prescaler #(
    parameter int DIV_W = cvb_pkg::CVB_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int MAX_SHIFT = (1 << DIV_W) - 1;
    localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected half period (wraps to all ones at the top select).
    always_comb begin
        limit = (CNT_W'(1) << div_sel) - CNT_W'(1);
    end

    // Tick on the last cycle of each half period.
    always_comb begin
        tick = run && (cnt_q == limit);
    end

    // Half-period cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R1: the counter never passes the terminal count of the half period.
    p_count_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));
endmodule

// File: rtl/cvb_burst_fsm.sv
// Module: cvb_burst_fsm
// Accepts a start request when idle and enabled with a nonzero length.
// It latches the divide select and the length, then toggles the pulse
// level on every prescaler tick. Status is cleared on the falling edge of
// the last pulse. A low enable aborts a burst at once.
module cvb_burst_fsm #(
    parameter int DIV_W = cvb_pkg::CVB_DIV_W,
    parameter int LEN_W = cvb_pkg::CVB_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [DIV_W-1:0] div_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             tick,
    output logic             restart,
    output logic             busy,
    output logic             pulse,
    output logic [DIV_W-1:0] div_lat
);
    logic             busy_q;
    logic             pulse_q;
    logic [LEN_W-1:0] rem_q;
    logic [DIV_W-1:0] div_q;
    logic             accept;

    // A request is taken only from idle, while enabled, with pulses to send.
    always_comb begin
        accept = !busy_q && enable && start && (len_in != '0);
    end

    // Burst state: pulse level, pulses left and the captured divide select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            pulse_q <= 1'b0;
            rem_q   <= '0;
            div_q   <= '0;
        end else if (!enable) begin
            busy_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            pulse_q <= 1'b1;
            rem_q   <= len_in;
            div_q   <= div_in;
        end else if (busy_q && tick) begin
            if (pulse_q) begin
                pulse_q <= 1'b0;
                if (rem_q == LEN_W'(1)) begin
                    busy_q <= 1'b0;
                end else begin
                    rem_q <= rem_q - LEN_W'(1);
                end
            end else begin
                pulse_q <= 1'b1;
            end
        end
    end

    assign restart = accept;
    assign busy    = busy_q;
    assign pulse   = pulse_q;
    assign div_lat = div_q;

    // R2: the pulse level is high only inside a burst.
    p_pulse_only_in_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> busy_q);

    // R3: status falls together with the last pulse, unless the burst was aborted.
    p_status_with_last_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($fell(pulse_q) || !$past(enable)));

    // R5: a running burst keeps its captured length and divide select.
    p_busy_ignores_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && enable && !tick) |=> ($stable(rem_q) && $stable(div_q)));

    // R6: a low enable leaves the block idle with the pulse level low.
    p_disable_aborts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy_q && !pulse_q));

    // R7: a zero burst length never starts a burst.
    p_zero_len_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && (len_in == '0)) |=> !busy_q);
endmodule

// File: rtl/cvb_out_mux.sv
// Module: cvb_out_mux
// Chooses the pin level: forced high, the pulse level when enabled, or
// low. Purely combinational, so overrides act in the same cycle.
module cvb_out_mux (
    input  logic force_high,
    input  logic enable,
    input  logic pulse,
    output logic pin
);
    import cvb_pkg::*;

    cvb_src_e src;

    // Priority: force-high, then enabled pulse, otherwise low.
    always_comb begin
        if (force_high) begin
            src = SRC_HIGH;
        end else if (enable) begin
            src = SRC_PULSE;
        end else begin
            src = SRC_LOW;
        end
    end

    // Map the selected source to a level.
    always_comb begin
        unique case (src)
            SRC_HIGH:  pin = 1'b1;
            SRC_PULSE: pin = pulse;
            default:   pin = 1'b0;
        endcase
    end
endmodule

// File: rtl/cv_burst_gen.sv
// Module: cv_burst_gen (top)
// Contrast-voltage pulse burst generator: the prescaler, the burst
// sequencer and the output selector. Assumes start is a one-cycle request
// and that reset is synchronous and active low.
module cv_burst_gen #(
    parameter int DIV_W = cvb_pkg::CVB_DIV_W,
    parameter int LEN_W = cvb_pkg::CVB_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             force_high,
    input  logic             start,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [LEN_W-1:0] burst_len,
    output logic             cv_out,
    output logic             burst_busy
);
    logic             tick;
    logic             restart;
    logic             busy;
    logic             pulse;
    logic [DIV_W-1:0] div_lat;

    cvb_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (busy),
        .div_sel (div_lat),
        .tick    (tick)
    );

    cvb_burst_fsm #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .start   (start),
        .div_in  (div_sel),
        .len_in  (burst_len),
        .tick    (tick),
        .restart (restart),
        .busy    (busy),
        .pulse   (pulse),
        .div_lat (div_lat)
    );

    cvb_out_mux u_mux (
        .force_high (force_high),
        .enable     (enable),
        .pulse      (pulse),
        .pin        (cv_out)
    );

    assign burst_busy = busy;

    // R4: a forced pin is high in the same cycle.
    p_force_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_high |-> cv_out);

    // R8: the cycle after a reset edge is idle and low.
    p_reset_idle_r8: assert property (@(posedge clk)
        !rst_n |=> (!burst_busy && (cv_out == force_high)));
endmodule

// File: tb/tb_cv_burst_gen.sv
module tb_cv_burst_gen;
    localparam int DIV_W = 3;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             enable;
    logic             force_high;
    logic             start;
    logic [DIV_W-1:0] div_sel;
    logic [LEN_W-1:0] burst_len;
    logic             cv_out;
    logic             burst_busy;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cv_burst_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .force_high (force_high),
        .start      (start),
        .div_sel    (div_sel),
        .burst_len  (burst_len),
        .cv_out     (cv_out),
        .burst_busy (burst_busy)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // mode 0: plain burst; 1: start/div/len disturbed mid-burst (R5); 2: force-high window (R4)
    task automatic run_burst(input int x, input int y, input int mode);
        int   h;
        int   total;
        int   rises;
        logic prev;
        logic f;
        logic exp_busy;
        logic exp_pulse;
        h     = 1 << x;
        total = (2 * y - 1) * h;
        rises = 0;
        prev  = 1'b0;
        f     = 1'b0;
        div_sel   = DIV_W'(x);
        burst_len = LEN_W'(y);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < total + 2 * h + 2; t++) begin
            exp_busy  = (t < total);
            exp_pulse = exp_busy && (((t / h) % 2) == 0);
            chk(mode == 1 ? "R5" : "R3", "status", burst_busy, exp_busy);
            if (f) chk("R4", "forced output", cv_out, 1'b1);
            else   chk(mode == 1 ? "R5" : "R1", "output", cv_out, exp_pulse);
            if (cv_out && !prev) rises++;
            prev = cv_out;
            if (mode == 1) begin
                if (t == 1) begin
                    start     = 1'b1;
                    div_sel   = DIV_W'(x ^ 1);
                    burst_len = LEN_W'(y + 3);
                end else if (t == 2) begin
                    start = 1'b0;
                end
            end
            if (mode == 2) begin
                if (t == h) begin
                    f = 1'b1;
                    force_high = 1'b1;
                end else if (t == 3 * h) begin
                    f = 1'b0;
                    force_high = 1'b0;
                end
            end
            @(negedge clk);
        end
        div_sel   = DIV_W'(x);
        burst_len = LEN_W'(y);
        if (mode != 2) chk("R2", "pulse count", rises == y, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ylist[4];
        ylist = '{1, 2, 3, 6};
        rst_n = 1'b0; enable = 1'b0; force_high = 1'b0; start = 1'b0;
        div_sel = '0; burst_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset output", cv_out, 1'b0);
        chk("R8", "reset status", burst_busy, 1'b0);
        enable = 1'b1;
        @(negedge clk);

        // R1 R2 R3: sweep divide select against several lengths
        for (int x = 0; x < 5; x++) begin
            for (int k = 0; k < 4; k++) begin
                run_burst(x, ylist[k], 0);
            end
        end
        run_burst(7, 2, 0);
        run_burst(3, 255, 0);

        // R5: start and new settings during a burst are ignored
        run_burst(1, 4, 1);
        run_burst(2, 3, 1);

        // R4: force-high over a running burst
        run_burst(1, 4, 2);
        run_burst(0, 5, 2);

        // R7: zero length
        burst_len = '0; div_sel = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R7", "status zero length", burst_busy, 1'b0);
            chk("R7", "output zero length", cv_out, 1'b0);
            @(negedge clk);
        end

        // R6: abort by disable
        div_sel = 3'd2; burst_len = 8'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6", "busy before abort", burst_busy, 1'b1);
        enable = 1'b0;
        #1;
        chk("R6", "output while disabled", cv_out, 1'b0);
        @(negedge clk);
        chk("R6", "status after abort", burst_busy, 1'b0);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", "no resume status", burst_busy, 1'b0);
        chk("R6", "no resume output", cv_out, 1'b0);

        // R4: force with enable low
        enable = 1'b0; force_high = 1'b1;
        #1;
        chk("R4", "forced while disabled", cv_out, 1'b1);
        @(negedge clk);
        force_high = 1'b0;

        // R6: start while disabled is discarded
        burst_len = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0; enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6", "start while disabled", burst_busy, 1'b0);

        // R8: reset in the middle of a burst
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "burst running", burst_busy, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8", "status after reset", burst_busy, 1'b0);
        chk("R8", "output after reset", cv_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule